// File: doc/BRIEF.md
# Serial Bitstream Configuration Master

This block loads a configuration bitstream into a target FPGA over a one-bit serial link. A `start` pulse begins a load: the block asserts the program request, waits for the target to acknowledge by raising INIT, then releases program. It waits for INIT to drop again, which means the target is ready for data. All pin signals on this block are active-high logical levels. Any polarity inversion needed by the board sits outside the block.

Bytes arrive on a valid/ready stream, and `s_last_i` marks the final byte. Before it accepts each byte, the block checks the target pins. INIT high while DONE is low is a CRC error, and the load aborts. Each accepted byte is sent most-significant bit first. Every bit takes three phases of `STEP_CYC` system cycles each: clock low, then data presented with the clock still low, then clock high. The target samples on the rising clock edge.

After the last byte, the block holds the data line high and keeps toggling the serial clock until DONE rises. If DONE does not rise in time, the load fails. The load ends with a single-cycle `ok_o` pulse, or a `fail_o` pulse with a reason code. A byte counter and a progress strobe let the system track how far the load has got.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, `busy_o`, `prog_o`, `cclk_o`, `s_ready_o`, `ok_o`, `fail_o` are 0 and `byte_count_o` is 0.
- R2: A `start_i` pulse while idle raises `prog_o`, with `cclk_o` low, until `init_i` is seen high. `prog_o` then drops.
- R3: If `init_i` is not seen high within `INIT_TMO` cycles of `prog_o` rising, the load fails with `fail_code_o` = 0.
- R4: After `prog_o` drops, no byte is accepted until `init_i` is low. If it stays high for `INIT_TMO` cycles, the load fails with `fail_code_o` = 1.
- R5: Each byte is sent MSB first: the k-th rising edge of `cclk_o` within a byte carries bit 7-k on `din_o`. `din_o` does not change while `cclk_o` stays high.
- R6: While `init_i` is high and `done_i` is low between bytes, `s_ready_o` stays low and the load aborts with `fail_code_o` = 2.
- R7: `byte_count_o` is cleared on start and rises by exactly one for each accepted byte.
- R8: `progress_o` pulses for one cycle each time an accepted byte makes `byte_count_o` a multiple of 2^`PROG_LOG2`.
- R9: After the byte flagged by `s_last_i`, `din_o` is 1 on every rising `cclk_o` edge. Clocking stops once `done_i` is high, and `ok_o` pulses with `busy_o` falling.
- R10: If `done_i` stays low for `DONE_TMO` cycles of completion clocking, the load fails with `fail_code_o` = 3.
- R11: `ok_o` and `fail_o` are single-cycle pulses that never occur together, and `busy_o` is low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a load when idle |
| s_data_i | input | 8 | Bitstream byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Marks the final byte |
| s_ready_o | output | 1 | Byte accepted when high with valid |
| init_i | input | 1 | Target INIT, 1 = active |
| done_i | input | 1 | Target DONE, 1 = configured |
| prog_o | output | 1 | Program request to target, 1 = active |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Load completed pulse |
| fail_o | output | 1 | Load failed pulse |
| fail_code_o | output | 2 | Failure reason, valid with fail_o |
| byte_count_o | output | CNT_W | Bytes accepted in this load |
| progress_o | output | 1 | Progress strobe |

## Verification
The bench builds the block with `STEP_CYC`=2, `INIT_TMO`=40, `DONE_TMO`=120 and `PROG_LOG2`=2. These values keep every timeout path to a few dozen cycles, and they make the progress strobe fire every fourth byte, so strobe counts can be checked on loads of only a few bytes. The short step also lets the bench run many random loads, with stream stalls and varied extra-clock counts before DONE, in a short run.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int STEP_CYC  = 4,
  parameter int INIT_TMO  = 100000,
  parameter int DONE_TMO  = 100000,
  parameter int CNT_W     = 24,
  parameter int PROG_LOG2 = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [7:0]       s_data_i,
  input  logic             s_valid_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             prog_o,
  output logic             cclk_o,
  output logic             din_o,
  output logic             busy_o,
  output logic             ok_o,
  output logic             fail_o,
  output logic [1:0]       fail_code_o,
  output logic [CNT_W-1:0] byte_count_o,
  output logic             progress_o
);
  localparam int TMAX = (INIT_TMO > DONE_TMO) ? INIT_TMO : DONE_TMO;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int SW   = $clog2(STEP_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PROG, S_REL, S_CHK, S_LO, S_DAT, S_HI, S_FIN
  } st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [SW-1:0]   stp;
  logic [7:0]      sh;
  logic [2:0]      bitn;
  logic            last_q;
  logic [CNT_W-1:0] cnt_nx;

  wire crc_bad   = init_i && !done_i;
  wire step_end  = (stp == SW'(STEP_CYC - 1));
  assign cnt_nx    = byte_count_o + 1'b1;
  assign s_ready_o = (st == S_CHK) && !crc_bad;
  assign prog_o    = (st == S_PROG);
  assign busy_o    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; stp <= '0; sh <= '0; bitn <= '0; last_q <= 1'b0;
      cclk_o <= 1'b0; din_o <= 1'b0; ok_o <= 1'b0; fail_o <= 1'b0;
      fail_code_o <= '0; byte_count_o <= '0; progress_o <= 1'b0;
    end else begin
      ok_o <= 1'b0;
      fail_o <= 1'b0;
      progress_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          st <= S_PROG; tmr <= '0; byte_count_o <= '0; din_o <= 1'b0; cclk_o <= 1'b0;
        end
        S_PROG:
          if (init_i) begin
            st <= S_REL; tmr <= '0;
          end else if (tmr == TW'(INIT_TMO - 1)) begin
            st <= S_IDLE; fail_o <= 1'b1; fail_code_o <= 2'd0;
          end else tmr <= tmr + 1'b1;
        S_REL:
          if (!init_i) st <= S_CHK;
          else if (tmr == TW'(INIT_TMO - 1)) begin
            st <= S_IDLE; fail_o <= 1'b1; fail_code_o <= 2'd1;
          end else tmr <= tmr + 1'b1;
        S_CHK:
          if (crc_bad) begin
            st <= S_IDLE; fail_o <= 1'b1; fail_code_o <= 2'd2;
          end else if (s_valid_i) begin
            sh <= s_data_i; last_q <= s_last_i; bitn <= '0; stp <= '0;
            byte_count_o <= cnt_nx;
            progress_o <= (cnt_nx[PROG_LOG2-1:0] == '0);
            st <= S_LO;
          end
        S_LO:
          if (step_end) begin
            stp <= '0; din_o <= sh[7]; st <= S_DAT;
          end else stp <= stp + 1'b1;
        S_DAT:
          if (step_end) begin
            stp <= '0; cclk_o <= 1'b1; st <= S_HI;
          end else stp <= stp + 1'b1;
        S_HI:
          if (step_end) begin
            stp <= '0; cclk_o <= 1'b0; sh <= {sh[6:0], 1'b0};
            if (bitn == 3'd7) begin
              tmr <= '0;
              st <= last_q ? S_FIN : S_CHK;
            end else begin
              bitn <= bitn + 1'b1; st <= S_LO;
            end
          end else stp <= stp + 1'b1;
        S_FIN: begin
          din_o <= 1'b1;
          if (done_i) begin
            st <= S_IDLE; ok_o <= 1'b1; cclk_o <= 1'b0;
          end else if (tmr == TW'(DONE_TMO - 1)) begin
            st <= S_IDLE; fail_o <= 1'b1; fail_code_o <= 2'd3; cclk_o <= 1'b0;
          end else begin
            tmr <= tmr + 1'b1;
            if (step_end) begin
              stp <= '0; cclk_o <= ~cclk_o;
            end else stp <= stp + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module serial_cfg_loader_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid_i,
  input logic             s_ready_o,
  input logic             init_i,
  input logic             done_i,
  input logic             prog_o,
  input logic             cclk_o,
  input logic             din_o,
  input logic             busy_o,
  input logic             ok_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] byte_count_o
);
  a_r2_prog_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> (!cclk_o && busy_o));
  a_r6_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> !(init_i && !done_i));
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o) |=> (byte_count_o == CNT_W'($past(byte_count_o) + 1'b1)));
  a_r5_din_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o && $past(cclk_o)) |-> (din_o == $past(din_o)));
  a_r11_outcome_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && fail_o));
  a_r11_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o || fail_o) |-> !busy_o);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o || fail_o) |=> !(ok_o || fail_o));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .init_i(init_i), .done_i(done_i), .prog_o(prog_o), .cclk_o(cclk_o),
  .din_o(din_o), .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o),
  .byte_count_o(byte_count_o)
);

// File: tb/tb_serial_cfg_loader.sv
`timescale 1ns/1ps
module tb_serial_cfg_loader;
  localparam int STEP = 2, ITMO = 40, DTMO = 120, CW = 16, PL2 = 2;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic s_valid_i = 1'b0, s_last_i = 1'b0, init_i = 1'b0, done_i = 1'b0;
  logic s_ready_o, prog_o, cclk_o, din_o, busy_o, ok_o, fail_o, progress_o;
  logic [1:0] fail_code_o;
  logic [CW-1:0] byte_count_o;

  always #2 clk = ~clk;

  serial_cfg_loader #(.STEP_CYC(STEP), .INIT_TMO(ITMO), .DONE_TMO(DTMO),
    .CNT_W(CW), .PROG_LOG2(PL2)) dut (.*);

  int checks = 0, failures = 0;
  logic [7:0] tx [0:63];
  logic [7:0] rx [0:63];
  logic [7:0] rsh;
  int bits, extra, nbytes, done_after, pcount;
  bit din_bad, ready_seen, prog_seen;
  bit r_ok, r_fail;
  logic [1:0] r_code;
  int r_cyc;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge cclk_o) begin
    bits++;
    if (bits <= 8 * nbytes) begin
      rsh = {rsh[6:0], din_o};
      if (bits % 8 == 0) rx[bits/8 - 1] = rsh;
      if (bits == 8 * nbytes && done_after == 0) done_i = 1'b1;
    end else begin
      extra++;
      if (din_o !== 1'b1) din_bad = 1'b1;
      if (extra == done_after) done_i = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (progress_o) pcount++;
    if (s_ready_o) ready_seen = 1'b1;
    if (prog_o) prog_seen = 1'b1;
  end

  function automatic int exp_progress(input int n);
    return n / (1 << PL2);
  endfunction

  task automatic prep(input int n, input int da);
    bits = 0; extra = 0; nbytes = n; done_after = da; din_bad = 0;
    pcount = 0; ready_seen = 0; prog_seen = 0; done_i = 0; init_i = 0;
    for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic handshake(input bit release_ok);
    while (!prog_o) @(negedge clk);
    repeat (5) @(negedge clk);
    init_i = 1'b1;
    while (prog_o) @(negedge clk);
    repeat (7) @(negedge clk);
    if (release_ok) init_i = 1'b0;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      s_data_i = tx[i]; s_last_i = (i == n - 1); s_valid_i = 1'b1;
      while (!s_ready_o) @(negedge clk);
      @(negedge clk);
      s_valid_i = 1'b0; s_last_i = 1'b0;
    end
  endtask

  task automatic wait_result(input int lim);
    r_cyc = 0;
    while (!(ok_o || fail_o) && r_cyc < lim) begin
      @(negedge clk); r_cyc++;
    end
    r_ok = ok_o; r_fail = fail_o; r_code = fail_code_o;
  endtask

  task automatic good_load(input int n, input int da);
    int mism;
    prep(n, da);
    pulse_start();
    handshake(1'b1);
    send(n);
    wait_result(2000);
    chk(prog_seen, "R2 program request seen", prog_seen, 1);
    chk(r_ok && !r_fail, "R9 ok pulse", r_ok, 1);
    mism = 0;
    for (int i = 0; i < n; i++) if (rx[i] !== tx[i]) mism++;
    chk(mism == 0, "R5 MSB-first bytes", mism, 0);
    chk(byte_count_o == CW'(n), "R7 byte count", int'(byte_count_o), n);
    chk(pcount == exp_progress(n), "R8 progress pulses", pcount, exp_progress(n));
    chk(!din_bad && extra == da, "R9 completion clocks with din high", extra, da);
    @(negedge clk);
    chk(!busy_o && !ok_o, "R11 idle after ok", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy_o && !prog_o && !cclk_o && !s_ready_o && !ok_o && !fail_o && byte_count_o == 0,
        "R1 reset state", {busy_o, prog_o, cclk_o, s_ready_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && byte_count_o == 0, "R1 idle after reset", busy_o, 0);

    good_load(9, 3);
    good_load(4, 0);
    for (int k = 0; k < 4; k++) good_load($urandom_range(1, 12), $urandom_range(0, 5));

    prep(2, -1);
    pulse_start();
    wait_result(200);
    chk(r_fail && r_code == 2'd0, "R3 init assert timeout code", r_code, 0);
    chk(r_cyc >= ITMO - 2 && r_cyc <= ITMO + 2, "R3 init assert timeout length", r_cyc, ITMO);
    chk(!ready_seen, "R3 no byte accepted", ready_seen, 0);

    prep(2, -1);
    pulse_start();
    handshake(1'b0);
    s_valid_i = 1'b1; s_data_i = 8'hA5;
    wait_result(200);
    s_valid_i = 1'b0;
    chk(r_fail && r_code == 2'd1, "R4 init release timeout code", r_code, 1);
    chk(!ready_seen && byte_count_o == 0, "R4 no byte before release", ready_seen, 0);

    prep(4, -1);
    pulse_start();
    handshake(1'b1);
    for (int i = 0; i < 3; i++) begin
      s_data_i = tx[i]; s_valid_i = 1'b1;
      while (!s_ready_o) @(negedge clk);
      @(negedge clk); s_valid_i = 1'b0;
    end
    while (bits < 24) @(negedge clk);
    init_i = 1'b1;
    ready_seen = 0;
    s_data_i = tx[3]; s_valid_i = 1'b1; s_last_i = 1'b1;
    wait_result(200);
    s_valid_i = 1'b0; s_last_i = 1'b0;
    chk(r_fail && r_code == 2'd2, "R6 crc abort code", r_code, 2);
    chk(!ready_seen && byte_count_o == 3, "R6 byte refused", int'(byte_count_o), 3);
    init_i = 1'b0;

    prep(3, -1);
    pulse_start();
    handshake(1'b1);
    send(3);
    while (bits < 24) @(negedge clk);
    wait_result(400);
    chk(r_fail && r_code == 2'd3, "R10 done timeout code", r_code, 3);
    chk(r_cyc >= DTMO - 4 && r_cyc <= DTMO + 8, "R10 done timeout length", r_cyc, DTMO);
    chk(!din_bad && extra > 0, "R9 clocking with din high while waiting", extra, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule